// File: doc/BRIEF.md
# Asynchronous Page-Mode NOR Flash Read Engine

This engine reads one page of 16-bit words from a parallel NOR flash using asynchronous page mode. One internal functional clock times everything, and that clock is never driven to the flash. The host asks for a read by giving a start word address, a word count, a chip-select index and two cycle counts. The engine then drives chip select, output enable, address valid, byte enables and the word address. It captures each data word on a clock edge and hands the word back with a one-cycle valid strobe.

Two programmable counts set the timing. The first count sets how many clock edges pass between accepting the request and sampling the first word. The page count sets the spacing between later samples. Because the address moves to the next word on each sample edge, the page count is also exactly how long each later address phase lasts. Within a page, the address changes only in its low-order word bits.

Top module: `pfr_page_rd`

## Requirements
- R1: Out of reset, busy_o and rd_valid_o are 0, every bit of flash_cs_no is 1, and flash_oe_no, flash_adv_no and both bits of flash_be_no are 1.
- R2: When req_valid_i is 1 at a clock edge while busy_o is 0, the request is accepted. From the next cycle, busy_o is 1, flash_oe_no is 0, and only bit req_cs_i (0 to 5) of flash_cs_no is 0.
- R3: Let F be first_cnt_i, taken as 1 when it is 0. The first word is captured exactly F edges after the accepting edge. In the cycle after that capture edge, rd_valid_o is 1 and rd_data_o holds flash_data_i as it was at that edge.
- R4: Let P be page_cnt_i as held at acceptance, taken as 1 when it is 0. Each later word is captured exactly P edges after the previous capture, with the same valid and data behaviour as R3.
- R5: Word k of the page (k from 0) is driven on flash_addr_o as {req_addr_i[9:2], (req_addr_i[1:0]+k) mod 4}. The address moves to word k+1 on the edge that captures word k, and it then holds for the whole address phase.
- R6: req_len_i encodes the number of words minus one, so 0 reads 1 word and 3 reads 4 words.
- R7: On the edge that captures the last word, busy_o falls to 0, every bit of flash_cs_no goes to 1 and flash_oe_no goes to 1. In that same cycle rd_valid_o shows the last word.
- R8: flash_adv_no is 0 from the cycle after acceptance until the first capture edge, and 1 at all other times.
- R9: Both bits of flash_be_no are 0 while busy_o is 1, and both are 1 otherwise.
- R10: While busy_o is 1, req_valid_i and every other request input are ignored. The running access keeps its chip select, addresses and timing, and no extra access follows it.
- R11: A count of 0 on first_cnt_i or page_cnt_i behaves exactly like a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal functional clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Read request strobe |
| req_addr_i | input | 10 | Start word address (address bits 10..1) |
| req_len_i | input | 2 | Word count minus one |
| req_cs_i | input | 3 | Chip-select index, 0 to 5 |
| first_cnt_i | input | 5 | Cycles from acceptance to the first sample |
| page_cnt_i | input | 5 | Cycles between later samples |
| busy_o | output | 1 | Access in progress |
| rd_valid_o | output | 1 | Captured word valid |
| rd_data_o | output | 16 | Captured word |
| flash_cs_no | output | 6 | Chip selects, active low |
| flash_oe_no | output | 1 | Output enable, active low |
| flash_adv_no | output | 1 | Address valid, active low |
| flash_be_no | output | 2 | Byte enables, active low |
| flash_addr_o | output | 10 | Word address to the flash |
| flash_data_i | input | 16 | Data from the flash |

## Verification
Every result is tied to the accepting edge. The first capture comes F edges after it, each later capture comes P edges after the previous one, and chip select, output enable and busy are released on the final capture edge, with F and P clamped to at least 1. The bench runs a cycle counter that starts at that accepting edge. In every cycle up to release, it samples on the falling clock edge and compares each output against values it derives from that count. The flash model returns a word computed from the current address, so the captured data also confirms the address sequence.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_PAGE  = 2'd2
  } pfr_state_e;
endpackage

// File: rtl/pfr_timer.sv
module pfr_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // zero is clamped to one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= (load_val_i == '0) ? CNT_W'(1) : load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expire_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pfr_addr_gen.sv
module pfr_addr_gen #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  // only the in-page word bits advance; they wrap inside the page
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (start_i)  addr_q <= base_i;
    else if (step_i)   addr_q <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/pfr_cs_dec.sv
module pfr_cs_dec #(
  parameter int NUM_CS = 6,
  parameter int SEL_W  = 3
) (
  input  logic              en_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [NUM_CS-1:0] cs_no
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_no[g] = !(en_i && (sel_i == SEL_W'(g)));
  end
endmodule

// File: rtl/pfr_page_rd.sv
module pfr_page_rd #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 6,
  parameter int CNT_W  = 5,
  parameter int PAGE_W = 2,
  localparam int SEL_W = $clog2(NUM_CS),
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [PAGE_W-1:0] req_len_i,
  input  logic [SEL_W-1:0]  req_cs_i,
  input  logic [CNT_W-1:0]  first_cnt_i,
  input  logic [CNT_W-1:0]  page_cnt_i,
  output logic              busy_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_CS-1:0] flash_cs_no,
  output logic              flash_oe_no,
  output logic              flash_adv_no,
  output logic [BE_W-1:0]   flash_be_no,
  output logic [ADDR_W-1:0] flash_addr_o,
  input  logic [DATA_W-1:0] flash_data_i
);
  import pfr_pkg::*;

  pfr_state_e        state_q, state_d;
  logic [PAGE_W-1:0] left_q;
  logic [CNT_W-1:0]  page_cnt_q;
  logic [SEL_W-1:0]  sel_q;
  logic              accept, sample, last, expire;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;

  assign accept = req_valid_i && (state_q == ST_IDLE);
  assign sample = expire && (state_q != ST_IDLE);
  assign last   = sample && (left_q == '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_FIRST;
      ST_FIRST,
      ST_PAGE:  if (sample) state_d = last ? ST_IDLE : ST_PAGE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      left_q     <= '0;
      page_cnt_q <= '0;
      sel_q      <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        left_q     <= req_len_i;
        page_cnt_q <= page_cnt_i;
        sel_q      <= req_cs_i;
      end else if (sample && !last) begin
        left_q <= left_q - PAGE_W'(1);
      end
    end
  end

  // capture path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= sample;
      if (sample) rd_data_o <= flash_data_i;
    end
  end

  assign tmr_load = accept || (sample && !last);
  assign tmr_val  = accept ? first_cnt_i : page_cnt_q;

  pfr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expire_o   (expire)
  );

  pfr_addr_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .step_i  (sample && !last),
    .base_i  (req_addr_i),
    .addr_o  (flash_addr_o)
  );

  pfr_cs_dec #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
    .en_i  (busy_o),
    .sel_i (sel_q),
    .cs_no (flash_cs_no)
  );

  assign busy_o       = (state_q != ST_IDLE);
  assign flash_oe_no  = !busy_o;
  assign flash_adv_no = (state_q != ST_FIRST);
  assign flash_be_no  = {BE_W{!busy_o}};
endmodule

// File: rtl/pfr_chk.sv
module pfr_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 6,
  parameter int CNT_W  = 5,
  parameter int PAGE_W = 2,
  localparam int SEL_W = $clog2(NUM_CS),
  localparam int BE_W  = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [PAGE_W-1:0] req_len_i,
  input logic [SEL_W-1:0]  req_cs_i,
  input logic [CNT_W-1:0]  first_cnt_i,
  input logic [CNT_W-1:0]  page_cnt_i,
  input logic              busy_o,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [NUM_CS-1:0] flash_cs_no,
  input logic              flash_oe_no,
  input logic              flash_adv_no,
  input logic [BE_W-1:0]   flash_be_no,
  input logic [ADDR_W-1:0] flash_addr_o,
  input logic [DATA_W-1:0] flash_data_i
);
  p_one_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($countones(~flash_cs_no) == 1 && !flash_oe_no));

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (&flash_cs_no && flash_oe_no));

  p_be_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (flash_be_no == '0));

  p_be_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (&flash_be_no));

  p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !rd_valid_o) |-> $stable(flash_addr_o));

  p_adv_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> flash_adv_no);

  p_adv_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_adv_no |-> busy_o);

  p_cs_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(flash_cs_no));
endmodule

bind pfr_page_rd pfr_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS), .CNT_W(CNT_W), .PAGE_W(PAGE_W)
) u_chk (.*);

// File: tb/pfr_page_rd_tb.sv
`timescale 1ns/1ps
module pfr_page_rd_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [1:0]  req_len = '0;
  logic [2:0]  req_cs = '0;
  logic [4:0]  first_cnt = '0;
  logic [4:0]  page_cnt = '0;
  logic        busy, rd_valid, oe_n, adv_n;
  logic [15:0] rd_data, fl_data;
  logic [5:0]  cs_n;
  logic [1:0]  be_n;
  logic [9:0]  fl_addr;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] data_of(logic [9:0] a);
    return {a[5:0], a} ^ 16'hC3A5;
  endfunction

  function automatic logic [9:0] addr_k(logic [9:0] base, int k);
    logic [1:0] lo = base[1:0] + 2'(k);
    return {base[9:2], lo};
  endfunction

  assign fl_data = data_of(fl_addr);

  pfr_page_rd u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_len_i(req_len), .req_cs_i(req_cs), .first_cnt_i(first_cnt), .page_cnt_i(page_cnt),
    .busy_o(busy), .rd_valid_o(rd_valid), .rd_data_o(rd_data), .flash_cs_no(cs_n),
    .flash_oe_no(oe_n), .flash_adv_no(adv_n), .flash_be_no(be_n), .flash_addr_o(fl_addr),
    .flash_data_i(fl_data)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // pins packed as {busy, cs_n, oe_n, adv_n, be_n, addr}
  task automatic run_req(logic [9:0] base, logic [1:0] len, logic [2:0] cs,
                         logic [4:0] f, logic [4:0] p, bit intrude);
    int fe = (f == 0) ? 1 : int'(f);
    int pe = (p == 0) ? 1 : int'(p);
    int total = fe + int'(len) * pe;
    @(negedge clk);
    chk("R2 idle before request", 64'(busy), 64'(0));
    req_valid = 1'b1; req_addr = base; req_len = len; req_cs = cs;
    first_cnt = f; page_cnt = p;
    for (int t = 0; t <= total; t++) begin
      int  done;
      bit  smp;
      @(negedge clk);
      if (t == 0) begin
        req_valid = 1'b0;
        // inputs after acceptance must not matter
        req_addr = 10'($urandom); req_len = 2'($urandom);
        first_cnt = 5'($urandom); page_cnt = 5'($urandom); req_cs = 3'($urandom_range(0, 5));
      end
      done = (t >= fe) ? 1 + (t - fe) / pe : 0;
      smp  = (t >= fe) && ((t - fe) % pe == 0);
      chk("R3 R4 R6 R11 valid timing", 64'(rd_valid), 64'(smp));
      if (smp) chk("R3 R4 R5 captured data", 64'(rd_data), 64'(data_of(addr_k(base, done - 1))));
      if (t < total)
        chk("R2 R5 R8 R9 R10 pins in access",
            64'({busy, cs_n, oe_n, adv_n, be_n, fl_addr}),
            64'({1'b1, ~(6'b1 << cs), 1'b0, (t < fe) ? 1'b0 : 1'b1, 2'b00, addr_k(base, done)}));
      else
        chk("R7 R9 release on last capture",
            64'({busy, cs_n, oe_n, adv_n, be_n}), 64'({1'b1 ^ 1'b1, 6'h3f, 1'b1, 1'b1, 2'b11}));
      if (intrude && total >= 2 && t == 0) req_valid = 1'b1;
      if (t == 1) req_valid = 1'b0;
    end
    // R10: nothing started after release
    @(negedge clk);
    chk("R10 no extra access", 64'({busy, rd_valid}), 64'(0));
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #12;
    chk("R1 reset pins", 64'({busy, rd_valid, cs_n, oe_n, adv_n, be_n}),
        64'({1'b0, 1'b0, 6'h3f, 1'b1, 1'b1, 2'b11}));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset release", 64'({busy, rd_valid, cs_n}), 64'({1'b0, 1'b0, 6'h3f}));
    // directed corners
    run_req(10'h100, 2'd3, 3'd0, 5'd0, 5'd0, 1'b0);   // R11 zero counts, back-to-back words
    run_req(10'h2c7, 2'd3, 3'd5, 5'd4, 5'd2, 1'b0);   // R5 in-page wrap, top select
    run_req(10'h055, 2'd0, 3'd2, 5'd1, 5'd9, 1'b0);   // R6 single word
    run_req(10'h3ff, 2'd3, 3'd3, 5'd31, 5'd31, 1'b1); // max counts, R10 intrusion
    run_req(10'h0a2, 2'd1, 3'd1, 5'd3, 5'd0, 1'b1);   // R11 page count zero, R10
    for (int i = 0; i < 40; i++)
      run_req(10'($urandom), 2'($urandom), 3'($urandom_range(0, 5)),
              5'($urandom_range(0, 12)), 5'($urandom_range(0, 12)), 1'($urandom));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule